// File: doc/BRIEF.md
# Transmit Completion Event Coalescer

This block decides when the transmit side should ask for a status update, and the interrupt that goes with it, so that not every finished descriptor costs the host an interrupt. Each advance of a send consumer index means one descriptor's data has finished its DMA move. The block records that fact as a pending event and adds one to a count of coalesced descriptors. Three things can turn pending events into a request: a microsecond countdown that has reached zero, the descriptor count reaching a programmed maximum, or a descriptor that was flagged for immediate flushing.

The countdown is driven by a prescaled one-microsecond strobe. It is reloaded from the programmed tick value only when a status update completes, whatever caused that update. A transmit event never reloads it. Once the countdown reaches zero it stays expired. Expiry alone never raises a request: at least one event must be pending. An update finished for another reason, such as receive activity, carries the send indices too. It therefore clears the pending state in the same way an acknowledged request does. A simple two-entry write port programs the tick value and the maximum count.

Top module: `txc_coalescer`

## Requirements
- R1: A strobe is produced once every CLK_MHZ core cycles, and the countdown decreases by one only on that strobe.
- R2: When `upd_ack` or `upd_other` is high at a clock edge, the countdown is loaded with the programmed tick value. An advance on `ci_adv` never reloads it.
- R3: The countdown stays at zero (expired) until the next reload. While it is expired, the tick value is nonzero and an event is pending, `upd_req` rises at the next clock edge.
- R4: `upd_req` never rises unless at least one event has been recorded since the last update, even if the countdown is expired.
- R5: A programmed tick value of zero disables the timer trigger, so expiry then raises no request.
- R6: Every `ci_adv` adds one to the descriptor count, which saturates at 2^CNT_W-1. A nonzero maximum raises a request once the count reaches it. A maximum of zero disables this trigger.
- R7: An advance with `ci_flush` high raises a request at the next clock edge.
- R8: Once raised, `upd_req` stays high until an edge on which `upd_ack` or `upd_other` is high, and it is low after that edge.
- R9: A completed update clears the pending flag, the flush flag and the count. An advance in the same cycle as the completion is kept as one new pending event with a count of one.
- R10: A write with `wr_sel`=0 sets the tick value and a write with `wr_sel`=1 sets the maximum from the low CNT_W bits of `wr_data`. A tick write leaves a running countdown unchanged and takes effect at the next reload.
- R11: After reset `upd_req` is low, the tick value, the maximum and the countdown are zero, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 1 | 0 selects the tick value, 1 selects the maximum count |
| wr_data | input | TICK_W | Write data |
| ci_adv | input | 1 | One send descriptor completed (consumer index advanced) |
| ci_flush | input | 1 | The completing descriptor asks for an immediate update |
| upd_other | input | 1 | A status update finished for a non-transmit cause |
| upd_ack | input | 1 | The requested status update has been done |
| upd_req | output | 1 | Status-update request, held until it completes |

## Verification
The bench builds the block with CLK_MHZ=3, TICK_W=8 and CNT_W=4. A microsecond is then three cycles, so countdowns of a few microseconds expire within tens of cycles. Sixteen advances are enough to push the descriptor count into saturation. These values put expiry, saturation, reload, an acknowledge that lands on an advance, and tick writes during a count all within a few thousand random cycles. A bench reference model predicts `upd_req` for every one of those cycles.

// File: rtl/txc_pkg.sv
package txc_pkg;
  typedef enum logic {
    SEL_TICK = 1'b0,
    SEL_MAX  = 1'b1
  } txc_sel_e;

  typedef struct packed {
    logic by_timer;
    logic by_count;
    logic by_flush;
  } txc_cause_t;
endpackage

// File: rtl/txc_us_prescaler.sv
module txc_us_prescaler #(
  parameter int CLK_MHZ = 125
) (
  input  logic clk,
  input  logic rst_n,
  output logic us_tick
);
  generate
    if (CLK_MHZ > 1) begin : g_div
      localparam int PW = $clog2(CLK_MHZ);
      localparam logic [PW-1:0] LAST = PW'(CLK_MHZ - 1);
      logic [PW-1:0] pc_q;

      function automatic logic [PW-1:0] f_pc_next(input logic [PW-1:0] pc);
        return (pc == LAST) ? '0 : pc + 1'b1;
      endfunction

      always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= f_pc_next(pc_q);
      end
      assign us_tick = (pc_q == LAST);

      a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        us_tick |=> !us_tick);
      a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q <= LAST);
    end else begin : g_pass
      assign us_tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/txc_countdown.sv
module txc_countdown #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic [TICK_W-1:0] load_val,
  input  logic              us_tick,
  output logic              expired
);
  logic [TICK_W-1:0] tmr_q;

  function automatic logic [TICK_W-1:0] f_tmr_next(
    input logic [TICK_W-1:0] cur, input logic ld,
    input logic [TICK_W-1:0] lv, input logic step);
    if (ld)                   return lv;
    if (step && cur != '0)    return cur - 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= f_tmr_next(tmr_q, reload, load_val, us_tick);
  end
  assign expired = (tmr_q == '0);

  a_r2_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> tmr_q == $past(load_val));
  a_r1_step_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !us_tick) |=> $stable(tmr_q));
  a_r3_hold_expired: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !reload) |=> expired);
endmodule

// File: rtl/txc_event_tracker.sv
module txc_event_tracker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             flush,
  input  logic             done,
  output logic             pend,
  output logic             flush_pend,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  logic             pend_q, fl_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] f_cnt_next(
    input logic [CNT_W-1:0] cur, input logic a, input logic clr);
    if (clr)                  return a ? CNT_W'(1) : '0;
    if (a && cur != CNT_TOP)  return cur + 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      fl_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= adv | (pend_q & ~done);
      fl_q   <= (adv & flush) | (fl_q & ~done);
      cnt_q  <= f_cnt_next(cnt_q, adv, done);
    end
  end

  assign pend       = pend_q;
  assign flush_pend = fl_q;
  assign cnt        = cnt_q;

  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_TOP && !done) |=> cnt_q == CNT_TOP);
  a_r9_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (done && adv) |=> (pend_q && cnt_q == CNT_W'(1)));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !adv) |=> (!pend_q && !fl_q && cnt_q == '0));
endmodule

// File: rtl/txc_coalescer.sv
module txc_coalescer
  import txc_pkg::*;
#(
  parameter int CLK_MHZ = 125,
  parameter int TICK_W  = 16,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [TICK_W-1:0] wr_data,
  input  logic              ci_adv,
  input  logic              ci_flush,
  input  logic              upd_other,
  input  logic              upd_ack,
  output logic              upd_req
);
  logic [TICK_W-1:0] tick_q;
  logic [CNT_W-1:0]  max_q;
  logic              us_tick, expired, upd_done, trig, req_q;
  logic              pend, flush_pend;
  logic [CNT_W-1:0]  cnt;
  txc_cause_t        cause;

  assign upd_done = upd_ack | upd_other;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      max_q  <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_MAX) max_q  <= wr_data[CNT_W-1:0];
      else                   tick_q <= wr_data;
    end
  end

  txc_us_prescaler #(.CLK_MHZ(CLK_MHZ)) u_pre (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick));

  txc_countdown #(.TICK_W(TICK_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .reload(upd_done), .load_val(tick_q),
    .us_tick(us_tick), .expired(expired));

  txc_event_tracker #(.CNT_W(CNT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .adv(ci_adv), .flush(ci_flush), .done(upd_done),
    .pend(pend), .flush_pend(flush_pend), .cnt(cnt));

  assign cause.by_timer = expired && (tick_q != '0);
  assign cause.by_count = (max_q != '0) && (cnt >= max_q);
  assign cause.by_flush = flush_pend;
  assign trig           = pend && (|cause);

  always_ff @(posedge clk) begin
    if (!rst_n)        req_q <= 1'b0;
    else if (upd_done) req_q <= 1'b0;
    else               req_q <= req_q | trig;
  end
  assign upd_req = req_q;

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req && !upd_done) |=> upd_req);
  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_req);
  a_r4_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_req) |-> $past(pend));
  a_r5_timer_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(upd_req) && $past(tick_q) == '0) |-> $past(cause.by_count || flush_pend));
endmodule

// File: tb/txc_coalescer_test.sv
module txc_coalescer_test;
  localparam int MHZ = 3;
  localparam int TW  = 8;
  localparam int CW  = 4;
  localparam int CTOP = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0, ci_adv = 0, ci_flush = 0, upd_other = 0, upd_ack = 0;
  logic [TW-1:0] wr_data = '0;
  logic upd_req;

  int n_run = 0, n_fail = 0, cyc_cnt = 0;
  int m_pc, m_tmr, m_tick, m_max, m_cnt;
  bit m_pend, m_fl, m_req;

  always #10 clk = ~clk;

  txc_coalescer #(.CLK_MHZ(MHZ), .TICK_W(TW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ci_adv(ci_adv), .ci_flush(ci_flush), .upd_other(upd_other), .upd_ack(upd_ack),
    .upd_req(upd_req));

  function automatic bit want_req(bit pend, bit fl, int tick, int tmr, int mx, int cnt);
    bit t_ok = (tick > 0) && (tmr == 0);
    bit c_ok = (mx > 0) && (cnt >= mx);
    return pend && (t_ok || c_ok || fl);
  endfunction

  function automatic int next_cnt(int cnt, bit adv, bit clr);
    int n = clr ? 0 : cnt;
    if (adv) n = (n + 1 > CTOP) ? CTOP : n + 1;
    return n;
  endfunction

  task automatic model_edge();
    bit us   = (m_pc == MHZ - 1);
    bit done = upd_ack | upd_other;
    bit trig = want_req(m_pend, m_fl, m_tick, m_tmr, m_max, m_cnt);
    m_req  = done ? 1'b0 : (m_req | trig);
    if (done)                m_tmr = m_tick;
    else if (us && m_tmr > 0) m_tmr = m_tmr - 1;
    m_pend = ci_adv | (m_pend & !done);
    m_fl   = (ci_adv & ci_flush) | (m_fl & !done);
    m_cnt  = next_cnt(m_cnt, ci_adv, done);
    if (wr_en) begin
      if (wr_sel) m_max = int'(wr_data) % (CTOP + 1);
      else        m_tick = int'(wr_data);
    end
    m_pc = us ? 0 : m_pc + 1;
  endtask

  task automatic check(string tag);
    n_run++;
    if (upd_req !== m_req) begin
      n_fail++;
      $display("FAIL %s: upd_req=%0b expected %0b at cycle %0d", tag, upd_req, m_req, cyc_cnt);
    end
  endtask

  // Called at a falling edge: drive, pass one rising edge, check at the next falling edge.
  task automatic cyc(bit adv, bit fl, bit oth, bit ack, bit we, bit sel, int data, string tag);
    ci_adv = adv; ci_flush = fl; upd_other = oth; upd_ack = ack;
    wr_en = we; wr_sel = sel; wr_data = TW'(data);
    @(posedge clk);
    model_edge();
    cyc_cnt++;
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    m_pc = 0; m_tmr = 0; m_tick = 0; m_max = 0; m_cnt = 0;
    m_pend = 0; m_fl = 0; m_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset state");
    rst_n = 1'b1;
    // R5 / R6: tick and max both zero, plain events never request
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0, 0, "R5 timer off");
    idle(30, "R5 no timer request");
    // R7 flush, R8 hold, R9 clear by ack
    cyc(1, 1, 0, 0, 0, 0, 0, "R7 flush");
    idle(5, "R8 held without ack");
    cyc(0, 0, 0, 1, 0, 0, 0, "R9 ack clears");
    idle(3, "R9 stays clear");
    // R6 threshold, cleared by other-cause update (R8)
    cyc(0, 0, 0, 0, 1, 1, 3, "R10 write max");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0, 0, "R6 threshold");
    idle(3, "R6 request held");
    cyc(0, 0, 1, 0, 0, 0, 0, "R8 other update clears");
    idle(3, "R8 clear");
    // R10: tick written, countdown still zero until next reload
    cyc(0, 0, 0, 0, 1, 1, 0, "R10 max off");
    cyc(0, 0, 0, 0, 1, 0, 5, "R10 write tick");
    cyc(1, 0, 0, 0, 0, 0, 0, "R10 old countdown still expired");
    idle(2, "R3 expired request");
    cyc(0, 0, 0, 1, 0, 0, 0, "R2 reload on ack");
    cyc(1, 0, 0, 0, 0, 0, 0, "R2 event no reload");
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0, 0, 0, "R2 events during count");
    idle(20, "R1 R3 countdown expiry");
    cyc(0, 0, 0, 1, 0, 0, 0, "R9 ack");
    idle(40, "R4 expired without events");
    // R9 same-cycle re-arm
    cyc(0, 0, 0, 0, 1, 1, 1, "R10 max one");
    cyc(1, 0, 0, 0, 0, 0, 0, "R6 max one");
    idle(2, "R6 max one req");
    cyc(1, 0, 0, 1, 0, 0, 0, "R9 ack with event");
    idle(3, "R9 rearmed request");
    cyc(0, 0, 0, 1, 0, 0, 0, "R9 ack");
    // R6 saturation
    cyc(0, 0, 0, 0, 1, 0, 0, "R10 tick off");
    cyc(0, 0, 0, 0, 1, 1, 0, "R10 max off");
    cyc(0, 0, 1, 0, 0, 0, 0, "R2 reload zero");
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, 0, 0, 0, "R6 saturating");
    cyc(0, 0, 0, 0, 1, 1, CTOP, "R6 max at top");
    idle(3, "R6 saturated count reaches max");
    cyc(0, 0, 0, 1, 0, 0, 0, "R9 ack");
    // random phase
    void'($urandom(32'h5eed_c0a1));
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      bit adv = (r < 30);
      bit fl  = adv && ($urandom_range(0, 15) == 0);
      bit ack = upd_req && ($urandom_range(0, 3) == 0);
      bit oth = ($urandom_range(0, 59) == 0);
      bit we  = ($urandom_range(0, 79) == 0);
      bit sel = $urandom_range(0, 1) == 1;
      int dat = sel ? int'($urandom_range(0, CTOP)) : int'($urandom_range(0, 12));
      cyc(adv, fl, oth, ack, we, sel, dat, "R1 R2 R3 R6 random");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule